// File: doc/BRIEF.md
# MDIO Management Command Bridge

The bridge turns one 32-bit command/status word into a complete clause-22 MDIO management transaction with an external PHY. Software writes the word with a PHY address, a PHY register number, an operation and, for writes, sixteen data bits. The bridge then generates the management clock and the whole serial frame on its own, preamble included. For a read it releases the data line during turnaround and collects the PHY's answer.

Completion is signalled by a ready flag in the same word. After a read, the low sixteen bits of the word carry the value returned by the PHY. That value is never altered: a missing PHY, which leaves the line pulled high, reads back as all ones.

The management clock is derived from the system clock by a parameterised divider. The outgoing bit changes only on the falling edge of the management clock, and incoming bits are captured on the rising edge.

Top module: `mdio_cmd_bridge`

## Requirements
- R1: After reset the word reads 32'h1000_0000 (ready bit 28 set, all other bits zero), and `mdc` and `mdio_oe` are low.
- R2: The word is laid out as: bits 15:0 data, bits 20:16 PHY register number, bits 25:21 PHY address, bits 27:26 operation, bit 28 ready, and bits 31:29 always zero. An accepted command's address, register and operation fields read back unchanged.
- R3: A write to the word while ready is 0 is ignored: the fields, the frame in progress and the completion time are unaffected. This includes a write in the very cycle a frame completes. A write while ready is 1 clears ready in the next cycle and starts a frame.
- R4: Every frame is sent MSB first: 32 ones, start bits 01, then the opcode, the 5-bit PHY address and the 5-bit register number. The opcode is 10 when command bit 27 is set and 01 otherwise.
- R5: In a write frame (bit 27 clear), the bridge drives all 64 bits. Turnaround is 10 and is followed by the 16 data bits. After completion the data field still holds the written value.
- R6: In a read frame (bit 27 set), `mdio_oe` is low for the last 18 bit times (turnaround and data). Sixteen bits of `mdio_i` are captured on the rising edges of `mdc`, MSB first, and placed in bits 15:0 when ready returns. 16'hFFFF is returned unchanged.
- R7: An `mdc` period is 2*DIV_HALF system clocks. `mdio_o` changes during a frame only together with a falling edge of `mdc`. Ready stays low for exactly 128*DIV_HALF clocks, which is below 64 microseconds at CLK_MHZ.
- R8: While ready is 1, `mdc` is held low and `mdio_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the command word |
| wr_data | input | 32 | Command word to write |
| rd_data | output | 32 | Command/status word readback |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
Two events can fall in the same clock edge: a software write to the word, and the completion of the frame that sets ready again. The bench drives the write strobe in the last busy cycle, so that it is sampled on the completion edge. It then requires that the write is ignored: the readback must hold the finished command's result and ready must stay high afterwards. The next write, issued one cycle later, must then start a normal frame.

// File: rtl/mdio_cmd_bridge.sv
module mdio_cmd_bridge #(
  parameter int CLK_MHZ  = 125,
  parameter int DIV_HALF = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int DW        = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam int LIMIT_CYC = CLK_MHZ * 64;
  localparam int LW        = $clog2(LIMIT_CYC + 1);
  localparam int TA_BIT    = 46;
  localparam int DATA_BIT  = 48;

  logic          ready;
  logic [1:0]    op;
  logic [4:0]    phy, rg;
  logic [15:0]   data, rd_sh;
  logic [63:0]   sh;
  logic [5:0]    bit_cnt;
  logic [DW-1:0] div_cnt;
  logic          mdc_q;
  logic [LW-1:0] busy_cnt;

  wire start   = wr_en && ready;
  wire is_rd   = wr_data[27];
  wire tick    = !ready && (div_cnt == DW'(DIV_HALF - 1));
  wire rise    = tick && !mdc_q;
  wire fall    = tick && mdc_q;
  wire [63:0] frame = {32'hFFFF_FFFF, 2'b01, is_rd ? 2'b10 : 2'b01,
                       wr_data[25:21], wr_data[20:16], 2'b10,
                       is_rd ? 16'h0000 : wr_data[15:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready    <= 1'b1;
      op       <= '0;
      phy      <= '0;
      rg       <= '0;
      data     <= '0;
      rd_sh    <= '0;
      sh       <= '0;
      bit_cnt  <= '0;
      div_cnt  <= '0;
      mdc_q    <= 1'b0;
      busy_cnt <= '0;
    end else if (start) begin
      ready    <= 1'b0;
      op       <= wr_data[27:26];
      phy      <= wr_data[25:21];
      rg       <= wr_data[20:16];
      data     <= wr_data[15:0];
      sh       <= frame;
      bit_cnt  <= '0;
      div_cnt  <= '0;
      mdc_q    <= 1'b0;
      busy_cnt <= '0;
    end else if (!ready) begin
      busy_cnt <= busy_cnt + 1'b1;
      div_cnt  <= tick ? '0 : div_cnt + 1'b1;
      if (rise) begin
        mdc_q <= 1'b1;
        if (op[1] && bit_cnt >= 6'(DATA_BIT)) rd_sh <= {rd_sh[14:0], mdio_i};
      end
      if (fall) begin
        mdc_q <= 1'b0;
        if (bit_cnt == 6'd63) begin
          ready <= 1'b1;
          if (op[1]) data <= rd_sh;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
          sh      <= {sh[62:0], 1'b0};
        end
      end
    end
  end

  assign mdc     = mdc_q;
  assign mdio_o  = sh[63];
  assign mdio_oe = !ready && !(op[1] && bit_cnt >= 6'(TA_BIT));
  assign rd_data = {3'b000, ready, op, phy, rg, data};

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!mdc && !mdio_oe));

  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && wr_en) |=> !rd_data[28]);

  p_busy_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && wr_en) |=> ($stable(rd_data[27:16])));

  p_out_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && $past(!ready) && (mdio_o != $past(mdio_o))) |-> $fell(mdc));

  p_within_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (busy_cnt < LW'(LIMIT_CYC)));
endmodule

// File: tb/test_mdio_cmd_bridge.sv
module test_mdio_cmd_bridge;
  localparam int DIV = 2;

  logic        clk = 0, rst_n = 0, wr_en = 0, mdio_i = 1;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic        mdc, mdio_o, mdio_oe;

  mdio_cmd_bridge #(.CLK_MHZ(125), .DIV_HALF(DIV)) i_mdio_cmd_bridge (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i));

  always #4 clk = ~clk;

  int vectors = 0, errors = 0;
  int rise_n = 0, busy_cycles = 0, per_bad = 0, cyc = 0, last_rise = 0;
  logic [63:0] cap_o, cap_oe, resp_w;
  logic mdc_q = 0;

  always @(negedge clk) begin
    if (mdc && !mdc_q) begin
      if (rise_n < 64) begin
        cap_o[63-rise_n]  = mdio_o;
        cap_oe[63-rise_n] = mdio_oe;
      end
      if (rise_n > 0 && cyc - last_rise != 2*DIV) per_bad++;
      last_rise = cyc;
      rise_n++;
    end
    if (!mdc && mdc_q) mdio_i = (rise_n < 64) ? resp_w[63-rise_n] : 1'b1;
    if (!rd_data[28]) busy_cycles++;
    mdc_q = mdc;
    cyc++;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_frame(input logic [31:0] c);
    return {32'hFFFF_FFFF, 2'b01, c[27] ? 2'b10 : 2'b01, c[25:21], c[20:16],
            2'b10, c[15:0]};
  endfunction

  function automatic logic [63:0] exp_oe(input logic [31:0] c);
    return c[27] ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
  endfunction

  task automatic run(input logic [31:0] cmd, input logic [15:0] resp, input int inj,
                     input logic [31:0] junk);
    logic [31:0] exp_rd;
    int n;
    rise_n = 0; busy_cycles = 0; per_bad = 0;
    resp_w = {48'hFFFF_FFFF_FFFF, resp};
    mdio_i = 1;
    @(negedge clk); wr_en = 1; wr_data = cmd;
    @(negedge clk); wr_en = 0;
    check(rd_data[28] == 1'b0, "R3 start clears ready", {63'b0, rd_data[28]}, 64'd0);
    n = 0;
    while (!rd_data[28]) begin
      if (n == inj) begin wr_en = 1; wr_data = junk; end else wr_en = 0;
      @(negedge clk);
      n++;
    end
    wr_en = 0;
    exp_rd = {3'b000, 1'b1, cmd[27:0]};
    if (cmd[27]) exp_rd[15:0] = resp;
    check(rd_data == exp_rd, cmd[27] ? "R6 read result word" : "R5 write result word R2",
          {32'b0, rd_data}, {32'b0, exp_rd});
    check((cap_o & exp_oe(cmd)) == (exp_frame(cmd) & exp_oe(cmd)), "R4 frame bits",
          cap_o & exp_oe(cmd), exp_frame(cmd) & exp_oe(cmd));
    check(cap_oe == exp_oe(cmd), cmd[27] ? "R6 enable pattern" : "R5 enable pattern",
          cap_oe, exp_oe(cmd));
    check(busy_cycles == 128*DIV && rise_n == 64 && per_bad == 0, "R7 timing",
          64'(busy_cycles), 64'(128*DIV));
    @(negedge clk);
    check(rd_data == exp_rd && !mdc && !mdio_oe, "R8 idle after frame R3",
          {32'b0, rd_data}, {32'b0, exp_rd});
  endtask

  initial begin
    #(8*200000);
    errors++;
    $display("FAIL watchdog R7 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [31:0] c;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(rd_data == 32'h1000_0000 && !mdc && !mdio_oe, "R1 reset state",
          {32'b0, rd_data}, 64'h1000_0000);
    check(rd_data[28] && !mdc && !mdio_oe, "R8 idle at reset", {63'b0, mdc}, 64'd0);
    // directed: write, read, absent PHY, op 11 as read
    run(32'h0462_BEEF, 16'h0000, -1, 0);
    run(32'h0A25_0000, 16'h1234, -1, 0);
    run(32'h0BE0_5555, 16'hFFFF, -1, 0);
    run(32'h0C21_0000, 16'h8001, -1, 0);
    // R3: write while busy, mid-frame and on the completion edge
    run(32'h0443_00AA, 16'h0000, 40, 32'h0BFF_FFFF);
    run(32'h0884_0000, 16'hC3C3, 128*DIV - 1, 32'h07FF_1111);
    check(rd_data[28] == 1'b1, "R3 ignored at completion", {63'b0, rd_data[28]}, 64'd1);
    for (int k = 0; k < 10; k++) begin
      c = $urandom;
      c[31:28] = 4'b0;
      run(c, 16'($urandom), -1, 0);
    end
    check(rd_data[31:29] == 3'b000, "R2 upper bits zero", {61'b0, rd_data[31:29]}, 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule